// File: doc/BRIEF.md
# Vector Length Control Registers

This block holds the loop-shape state that a vector-capable core consults on every vector operation: the maximum vector length, the current vector length, the sub-vector length, a source element offset, a destination element offset and a destination offset inside the sub-vector. Software reaches it through a single-cycle register port: a select, a write strobe, write data, and a combinational read-data output. Every write is legalised before it is stored. Each length and offset is clamped against the other live fields, so the stored state is always self-consistent.

Besides the three length registers, a combined state register gathers every field into one word. Reading it returns the lengths in minus-one form. Writing it loads all six fields in one cycle. The register port is a control path, not a data stream: a write is accepted in the cycle its strobe is high, there is no back-pressure, and a read needs no handshake.

Top module: `vlen_csr_unit`

## Requirements
- R1: After reset, VL and MVL read 0, SUBVL reads 1, all offsets are 0, and the combined state register reads 0.
- R2: Select codes are 0 = MVL, 1 = VL, 2 = SUBVL, 3 = combined state. Codes 4 to 7 read as 0, and a write to them leaves every field unchanged.
- R3: Writing MVL with value v stores min(v+1, 64). A read of MVL returns the stored value directly.
- R4: After a write to MVL, VL is reduced to the new MVL if it exceeds it, and it is left alone otherwise.
- R5: Writing VL with value v stores min(MVL, v+1). A read of VL returns the stored value.
- R6: Writing SUBVL with value v stores v clamped to the range 1..4. A read returns the stored value.
- R7: The combined state word reads as follows: bits 5:0 = max(VL,1)-1, bits 11:6 = max(MVL,1)-1, bits 17:12 = source offset, bits 23:18 = destination offset, bits 25:24 = max(SUBVL,1)-1, bits 27:26 = sub-vector destination offset. All higher bits are 0.
- R8: A write to the combined state register uses the same field positions as R7. MVL becomes field+1. VL becomes min(new MVL, field+1), so it is clamped against the MVL written in the same cycle. SUBVL becomes field+1.
- R9: Source and destination offsets are held at most max(VL,1)-1, and the sub-vector destination offset is held at most SUBVL-1, with the bounds taken from the values written in the same cycle.
- R10: Any write that lowers VL or SUBVL also pulls the stored offsets down to the new bounds.
- R11: Write data of all ones to MVL or VL does not wrap around when one is added. MVL becomes 64, and VL becomes MVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_sel | input | 3 | Register select (R2 encoding) |
| csr_we | input | 1 | Write strobe, one write per high cycle |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for the selected register, combinational |

## Verification
The bench builds the block with its default parameters: 6-bit length fields, so lengths reach 64, 2-bit sub-vector fields, so SUBVL reaches 4, and a 32-bit data path. These values make the top clamps reachable. A 32-bit all-ones write exercises the plus-one overflow, and offsets up to 63 can be written against a VL of 1. The directed tasks walk VL downward with offsets already stored, so the re-clamping of stale offsets is observed through the combined state readback.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  typedef enum logic [2:0] {
    SEL_MVL   = 3'd0,
    SEL_VL    = 3'd1,
    SEL_SUBVL = 3'd2,
    SEL_STATE = 3'd3
  } vlc_sel_e;
endpackage

// File: rtl/vlc_next.sv
// Computes the candidate next lengths and raw offsets for one register write.
module vlc_next #(
  parameter int LEN_W  = 6,
  parameter int SUB_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                csr_we,
  input  logic [2:0]          csr_sel,
  input  logic [DATA_W-1:0]   csr_wdata,
  input  logic [LEN_W:0]      mvl_q,
  input  logic [LEN_W:0]      vl_q,
  input  logic [SUB_W:0]      sub_q,
  input  logic [LEN_W-1:0]    src_q,
  input  logic [LEN_W-1:0]    dst_q,
  input  logic [SUB_W-1:0]    dsv_q,
  output logic [LEN_W:0]      mvl_n,
  output logic [LEN_W:0]      vl_n,
  output logic [SUB_W:0]      sub_n,
  output logic [LEN_W-1:0]    src_c,
  output logic [LEN_W-1:0]    dst_c,
  output logic [SUB_W-1:0]    dsv_c
);
  import vlc_pkg::*;

  localparam int LEN_CW = LEN_W + 1;
  localparam int SUB_CW = SUB_W + 1;
  localparam int F_VL   = 0;
  localparam int F_MVL  = LEN_W;
  localparam int F_SRC  = 2 * LEN_W;
  localparam int F_DST  = 3 * LEN_W;
  localparam int F_SUB  = 4 * LEN_W;
  localparam int F_DSV  = 4 * LEN_W + SUB_W;
  localparam logic [LEN_CW-1:0] MAX_LEN   = LEN_CW'(1) << LEN_W;
  localparam logic [DATA_W:0]   MAX_LEN_W = (DATA_W+1)'(MAX_LEN);
  localparam logic [SUB_CW-1:0] SUB_MAX   = SUB_CW'(1) << SUB_W;
  localparam logic [DATA_W-1:0] SUB_MAX_D = DATA_W'(SUB_MAX);

  logic [DATA_W:0]     wp1;
  logic [LEN_CW-1:0]   mvl_w, vl_w;
  logic [SUB_CW-1:0]   sub_w;
  logic [LEN_W-1:0]    f_vl, f_mvl, f_src, f_dst;
  logic [SUB_W-1:0]    f_sub, f_dsv;
  logic [LEN_CW-1:0]   st_mvl, st_vl_raw, st_vl;
  logic [SUB_CW-1:0]   st_sub;

  // plus-one widened by a bit so all-ones data cannot wrap
  assign wp1   = {1'b0, csr_wdata} + (DATA_W+1)'(1);
  assign mvl_w = (wp1 > MAX_LEN_W) ? MAX_LEN : wp1[LEN_CW-1:0];
  assign vl_w  = (wp1 > (DATA_W+1)'(mvl_q)) ? mvl_q : wp1[LEN_CW-1:0];
  assign sub_w = (csr_wdata == '0) ? SUB_CW'(1) :
                 (csr_wdata > SUB_MAX_D) ? SUB_MAX : csr_wdata[SUB_CW-1:0];

  assign f_vl  = csr_wdata[F_VL  +: LEN_W];
  assign f_mvl = csr_wdata[F_MVL +: LEN_W];
  assign f_src = csr_wdata[F_SRC +: LEN_W];
  assign f_dst = csr_wdata[F_DST +: LEN_W];
  assign f_sub = csr_wdata[F_SUB +: SUB_W];
  assign f_dsv = csr_wdata[F_DSV +: SUB_W];

  // combined write: MVL settles first, VL is bounded by that new MVL
  assign st_mvl    = {1'b0, f_mvl} + LEN_CW'(1);
  assign st_vl_raw = {1'b0, f_vl} + LEN_CW'(1);
  assign st_vl     = (st_vl_raw > st_mvl) ? st_mvl : st_vl_raw;
  assign st_sub    = {1'b0, f_sub} + SUB_CW'(1);

  always_comb begin
    mvl_n = mvl_q;
    vl_n  = vl_q;
    sub_n = sub_q;
    src_c = src_q;
    dst_c = dst_q;
    dsv_c = dsv_q;
    if (csr_we) begin
      case (csr_sel)
        SEL_MVL: begin
          mvl_n = mvl_w;
          vl_n  = (vl_q > mvl_w) ? mvl_w : vl_q;
        end
        SEL_VL:    vl_n  = vl_w;
        SEL_SUBVL: sub_n = sub_w;
        SEL_STATE: begin
          mvl_n = st_mvl;
          vl_n  = st_vl;
          sub_n = st_sub;
          src_c = f_src;
          dst_c = f_dst;
          dsv_c = f_dsv;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vlc_offs_clamp.sv
// Bounds the element offsets by the next VL and the sub-vector offset by the next SUBVL.
module vlc_offs_clamp #(
  parameter int LEN_W  = 6,
  parameter int SUB_W  = 2,
  parameter int N_OFFS = 2
) (
  input  logic [LEN_W:0]                  vl_n,
  input  logic [SUB_W:0]                  sub_n,
  input  logic [N_OFFS-1:0][LEN_W-1:0]    offs_c,
  input  logic [SUB_W-1:0]                dsv_c,
  output logic [N_OFFS-1:0][LEN_W-1:0]    offs_o,
  output logic [SUB_W-1:0]                dsv_o
);
  localparam int LEN_CW = LEN_W + 1;
  localparam int SUB_CW = SUB_W + 1;

  logic [LEN_W-1:0] bound;
  logic [SUB_W-1:0] sub_bound;

  // a zero VL gives a bound of zero instead of wrapping to all ones
  assign bound     = (vl_n == '0) ? '0 : LEN_W'(vl_n - LEN_CW'(1));
  assign sub_bound = (sub_n == '0) ? '0 : SUB_W'(sub_n - SUB_CW'(1));

  for (genvar i = 0; i < N_OFFS; i++) begin : g_offs
    assign offs_o[i] = (offs_c[i] > bound) ? bound : offs_c[i];
  end

  assign dsv_o = (dsv_c > sub_bound) ? sub_bound : dsv_c;
endmodule

// File: rtl/vlc_pack.sv
// Read multiplexer, including the minus-one packing of the combined word.
module vlc_pack #(
  parameter int LEN_W  = 6,
  parameter int SUB_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic [2:0]         csr_sel,
  input  logic [LEN_W:0]     mvl_q,
  input  logic [LEN_W:0]     vl_q,
  input  logic [SUB_W:0]     sub_q,
  input  logic [LEN_W-1:0]   src_q,
  input  logic [LEN_W-1:0]   dst_q,
  input  logic [SUB_W-1:0]   dsv_q,
  output logic [DATA_W-1:0]  csr_rdata
);
  import vlc_pkg::*;

  localparam int LEN_CW = LEN_W + 1;
  localparam int SUB_CW = SUB_W + 1;
  localparam int F_VL   = 0;
  localparam int F_MVL  = LEN_W;
  localparam int F_SRC  = 2 * LEN_W;
  localparam int F_DST  = 3 * LEN_W;
  localparam int F_SUB  = 4 * LEN_W;
  localparam int F_DSV  = 4 * LEN_W + SUB_W;

  logic [LEN_W-1:0]  vl_enc, mvl_enc;
  logic [SUB_W-1:0]  sub_enc;
  logic [DATA_W-1:0] state_word;

  assign vl_enc  = (vl_q  == '0) ? '0 : LEN_W'(vl_q  - LEN_CW'(1));
  assign mvl_enc = (mvl_q == '0) ? '0 : LEN_W'(mvl_q - LEN_CW'(1));
  assign sub_enc = (sub_q == '0) ? '0 : SUB_W'(sub_q - SUB_CW'(1));

  always_comb begin
    state_word = '0;
    state_word[F_VL  +: LEN_W] = vl_enc;
    state_word[F_MVL +: LEN_W] = mvl_enc;
    state_word[F_SRC +: LEN_W] = src_q;
    state_word[F_DST +: LEN_W] = dst_q;
    state_word[F_SUB +: SUB_W] = sub_enc;
    state_word[F_DSV +: SUB_W] = dsv_q;
  end

  always_comb begin
    case (csr_sel)
      SEL_MVL:   csr_rdata = DATA_W'(mvl_q);
      SEL_VL:    csr_rdata = DATA_W'(vl_q);
      SEL_SUBVL: csr_rdata = DATA_W'(sub_q);
      SEL_STATE: csr_rdata = state_word;
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit #(
  parameter int LEN_W  = 6,
  parameter int SUB_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        csr_sel,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata
);
  localparam int LEN_CW = LEN_W + 1;
  localparam int SUB_CW = SUB_W + 1;

  logic [LEN_CW-1:0] mvl_q, vl_q, mvl_n, vl_n;
  logic [SUB_CW-1:0] sub_q, sub_n;
  logic [LEN_W-1:0]  src_q, dst_q, src_c, dst_c;
  logic [SUB_W-1:0]  dsv_q, dsv_c, dsv_n;
  logic [1:0][LEN_W-1:0] offs_c, offs_n;

  vlc_next #(.LEN_W(LEN_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_next (
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .mvl_q(mvl_q), .vl_q(vl_q), .sub_q(sub_q),
    .src_q(src_q), .dst_q(dst_q), .dsv_q(dsv_q),
    .mvl_n(mvl_n), .vl_n(vl_n), .sub_n(sub_n),
    .src_c(src_c), .dst_c(dst_c), .dsv_c(dsv_c)
  );

  assign offs_c = {dst_c, src_c};

  vlc_offs_clamp #(.LEN_W(LEN_W), .SUB_W(SUB_W), .N_OFFS(2)) u_clamp (
    .vl_n(vl_n), .sub_n(sub_n), .offs_c(offs_c), .dsv_c(dsv_c),
    .offs_o(offs_n), .dsv_o(dsv_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvl_q <= '0;
      vl_q  <= '0;
      sub_q <= SUB_CW'(1);
      src_q <= '0;
      dst_q <= '0;
      dsv_q <= '0;
    end else begin
      mvl_q <= mvl_n;
      vl_q  <= vl_n;
      sub_q <= sub_n;
      src_q <= offs_n[0];
      dst_q <= offs_n[1];
      dsv_q <= dsv_n;
    end
  end

  vlc_pack #(.LEN_W(LEN_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_pack (
    .csr_sel(csr_sel), .mvl_q(mvl_q), .vl_q(vl_q), .sub_q(sub_q),
    .src_q(src_q), .dst_q(dst_q), .dsv_q(dsv_q), .csr_rdata(csr_rdata)
  );
endmodule

// File: rtl/vlc_check.sv
module vlc_check #(
  parameter int LEN_W  = 6,
  parameter int SUB_W  = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        csr_sel,
  input logic              csr_we,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [LEN_W:0]    mvl_q,
  input logic [LEN_W:0]    vl_q,
  input logic [SUB_W:0]    sub_q,
  input logic [LEN_W-1:0]  src_q,
  input logic [LEN_W-1:0]  dst_q,
  input logic [SUB_W-1:0]  dsv_q
);
  localparam int LEN_CW = LEN_W + 1;
  localparam int SUB_CW = SUB_W + 1;
  localparam logic [LEN_CW-1:0] TOP_LEN = LEN_CW'(1) << LEN_W;
  localparam logic [SUB_CW-1:0] TOP_SUB = SUB_CW'(1) << SUB_W;

  logic [LEN_CW-1:0] elem_lim;
  assign elem_lim = (vl_q > LEN_CW'(0)) ? vl_q - LEN_CW'(1) : LEN_CW'(0);

  p_vl_within_mvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= mvl_q);

  p_mvl_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_q <= TOP_LEN);

  p_subvl_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q >= SUB_CW'(1)) && (sub_q <= TOP_SUB));

  p_offs_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, src_q} <= elem_lim) && ({1'b0, dst_q} <= elem_lim));

  p_dsv_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, dsv_q} < sub_q);

  p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel[2]) |=> ($stable(mvl_q) && $stable(vl_q) && $stable(sub_q)
                                && $stable(src_q) && $stable(dst_q) && $stable(dsv_q)));

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 3'd0 && csr_wdata == '1) |=> (mvl_q == TOP_LEN));
endmodule

bind vlen_csr_unit vlc_check #(.LEN_W(LEN_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .mvl_q(mvl_q), .vl_q(vl_q), .sub_q(sub_q),
  .src_q(src_q), .dst_q(dst_q), .dsv_q(dsv_q)
);

// File: tb/sim_vlen_csr_unit.sv
module sim_vlen_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_MVL = 3'd0, S_VL = 3'd1, S_SUB = 3'd2, S_ST = 3'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  csr_sel = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vlen_csr_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // combined word in the R7 layout, from minus-one length codes
  function automatic logic [31:0] pk(int vlf, int mvlf, int src, int dst, int subf, int dsv);
    return 32'(vlf) | (32'(mvlf) << 6) | (32'(src) << 12) | (32'(dst) << 18)
         | (32'(subf) << 24) | (32'(dsv) << 26);
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [2:0] s, input logic [31:0] exp);
    csr_sel = s;
    #1;
    checks++;
    if (csr_rdata !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", tag, s, csr_rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 mvl", S_MVL, 0);
    chk("R1 vl", S_VL, 0);
    chk("R1 subvl", S_SUB, 1);
    chk("R1 state", S_ST, 0);
  endtask

  task automatic t_mvl();
    wr(S_MVL, 9);            chk("R3 mvl 9", S_MVL, 10);
    wr(S_MVL, 200);          chk("R3 mvl clamp", S_MVL, 64);
    wr(S_MVL, 63);           chk("R3 mvl 63", S_MVL, 64);
    wr(S_MVL, 32'hFFFF_FFFF); chk("R11 mvl all ones", S_MVL, 64);
  endtask

  task automatic t_vl();
    wr(S_VL, 4);             chk("R5 vl 4", S_VL, 5);
    wr(S_VL, 100);           chk("R5 vl clamp", S_VL, 64);
    wr(S_VL, 32'hFFFF_FFFF); chk("R11 vl all ones", S_VL, 64);
    wr(S_MVL, 7);            chk("R4 mvl lowered", S_MVL, 8);
    chk("R4 vl pulled down", S_VL, 8);
    wr(S_VL, 2);             chk("R5 vl 2", S_VL, 3);
    wr(S_MVL, 19);           chk("R4 vl kept", S_VL, 3);
  endtask

  task automatic t_subvl();
    wr(S_SUB, 0);  chk("R6 subvl zero", S_SUB, 1);
    wr(S_SUB, 3);  chk("R6 subvl 3", S_SUB, 3);
    wr(S_SUB, 9);  chk("R6 subvl high", S_SUB, 4);
    wr(S_SUB, 1);  chk("R6 subvl 1", S_SUB, 1);
  endtask

  task automatic t_state();
    wr(S_ST, pk(10, 20, 5, 40, 2, 3));
    chk("R8 state vl", S_VL, 11);
    chk("R8 state mvl", S_MVL, 21);
    chk("R8 state subvl", S_SUB, 3);
    chk("R7 R9 state word", S_ST, pk(10, 20, 5, 10, 2, 2));
    wr(S_ST, pk(50, 7, 0, 0, 0, 0));
    chk("R8 vl vs new mvl", S_VL, 8);
    wr(S_ST, pk(0, 0, 33, 63, 0, 3));
    chk("R9 vl one bound", S_ST, pk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_reclamp();
    wr(S_ST, pk(30, 40, 25, 20, 3, 3));
    chk("R8 setup", S_ST, pk(30, 40, 25, 20, 3, 3));
    wr(S_VL, 9);
    chk("R10 vl shrink", S_ST, pk(9, 40, 9, 9, 3, 3));
    wr(S_SUB, 2);
    chk("R10 subvl shrink", S_ST, pk(9, 40, 9, 9, 1, 1));
    wr(S_MVL, 4);
    chk("R10 mvl shrink", S_ST, pk(4, 4, 4, 4, 1, 1));
  endtask

  task automatic t_reserved();
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R2 reserved write", S_ST, pk(4, 4, 4, 4, 1, 1));
    chk("R2 reserved read", 3'd5, 0);
    wr(3'd7, 0);
    chk("R2 reserved write 7", S_MVL, 5);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_mvl();
    t_vl();
    t_subvl();
    t_state();
    t_reclamp();
    t_reserved();
    do_reset();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule